// File: doc/BRIEF.md
# RAM-Based Repeating Pattern Generator

This block plays out a user-defined bit pattern that repeats forever. The pattern is held in an internal byte memory of 512 entries. A host loads that memory indirectly: it first sets an address register, then writes data bytes. The address moves up by one after every write, so a whole pattern can be streamed in with a single address load.

A length field of 9 bits chooses how many bytes are replayed. Each byte is sent either most significant bit first or least significant bit first. After the last selected byte the sequence returns to byte zero.

Patterns are stored in whole bytes. A pattern whose bit length is not a multiple of eight is written over and over until it fills a whole number of bytes. For example, a 5-bit pattern repeated eight times fills exactly 5 bytes.

A clock enable advances the stream one bit per enabled cycle. While the enable is low the serial output keeps the last bit sent. A restart input sets the replay position back to the first bit of byte zero.

Top module: `ram_pattern_gen`

## Requirements
- R1: After reset the serial output is 0, the replay position is bit 0 of byte 0 and the write address is 0.
- R2: A cycle with `addr_load` high sets the write address to `addr_in`. A write in that same cycle still goes to the old address.
- R3: A cycle with `wr_en` high stores `wr_data` at the write address. Unless `addr_load` is also high, the address then moves up by one, and it wraps from 511 to 0.
- R4: With `lsb_first` = 0, each byte is sent in the order bit 7, bit 6, and so on down to bit 0.
- R5: With `lsb_first` = 1, each byte is sent in the order bit 0, bit 1, and so on up to bit 7.
- R6: With a length value L, bytes 0 to L are replayed in ascending order, and byte 0 follows byte L. L = 0 repeats a single byte, and L = 511 uses the whole memory.
- R7: If the byte just finished has an index greater than or equal to L, the next byte is byte 0. This covers L being lowered below the current byte while a byte is being sent.
- R8: Each cycle with `clk_en` high puts the next pattern bit on `sdata`, one register stage after the edge. While `clk_en` is low, `sdata` keeps its value and the replay position does not move.
- R9: `restart` sets the replay position to bit 0 of byte 0 and takes priority over `clk_en`. In that cycle `sdata` keeps its value, and the next enabled cycle sends the first bit of byte 0.
- R10: A 5-bit pattern written eight times into 5 bytes, with L = 4 and most significant bit first, appears on `sdata` as an unbroken repeat of its 5 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load the write address from `addr_in` |
| addr_in | input | 9 | New write address |
| wr_en | input | 1 | Write `wr_data` at the write address, then move the address up by one |
| wr_data | input | 8 | Pattern byte to store |
| len_cfg | input | 9 | Length value L; bytes 0 to L are replayed |
| lsb_first | input | 1 | 0: most significant bit first; 1: least significant bit first |
| restart | input | 1 | Return the replay position to bit 0 of byte 0 |
| clk_en | input | 1 | Advance the stream by one bit |
| sdata | output | 1 | Serial pattern output |

## Verification
The replay is tried with several kinds of memory content, each of which tells a different fault apart:
- Bytes filled from an arithmetic sequence, replayed at lengths of 1, 3, 4, 8 and 512 bytes in both bit orders. This separates bit-order faults from wrap-point faults.
- An extra write after a full fill, which must land on byte 0, and two bytes placed through an address load. These tell address wrapping apart from address loading.
- A 5-bit pattern stored as five bytes, replayed continuously. This shows that byte joins and the wrap leave no seam.
- The length lowered in the middle of a byte, an enable held low, and a restart issued with the enable high. These separate the `>=` wrap test from an equality test, and check hold and priority behaviour.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_DEPTH  = 512;

  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;
endpackage

// File: rtl/rpg_host_port.sv
module rpg_host_port #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [AW-1:0]     addr_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic [AW-1:0] wr_ptr;

  function automatic logic [AW-1:0] bump_addr(input logic [AW-1:0] a);
    return (a == AW'(DEPTH - 1)) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)          wr_ptr <= '0;
    else if (addr_load)  wr_ptr <= addr_in;
    else if (wr_en)      wr_ptr <= bump_addr(wr_ptr);
  end

  assign mem_we    = wr_en;
  assign mem_waddr = wr_ptr;
  assign mem_wdata = wr_data;

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_load |=> mem_waddr == $past(addr_in));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_load && mem_waddr != AW'(DEPTH - 1)) |=> mem_waddr == $past(mem_waddr) + 1'b1);

  p_addr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_load && mem_waddr == AW'(DEPTH - 1)) |=> mem_waddr == '0);

  p_addr_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !addr_load) |=> $stable(mem_waddr));
endmodule

// File: rtl/rpg_pattern_ram.sv
module rpg_pattern_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/rpg_serializer.sv
module rpg_serializer
  import rpg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH),
  localparam int BW    = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     len_cfg,
  input  logic              lsb_first,
  input  logic              restart,
  input  logic              clk_en,
  input  logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic              sdata
);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic [AW-1:0] byte_ptr;
  logic [BW-1:0] bit_idx;
  bit_order_e    order;
  logic          byte_done;
  logic          ptr_wrap;
  logic          advance;

  function automatic logic pick_bit(input logic [DATA_W-1:0] b,
                                    input logic [BW-1:0] i,
                                    input bit_order_e o);
    logic [BW-1:0] j;
    j = (o == ORDER_LSB) ? i : LAST_BIT - i;
    return b[j];
  endfunction

  function automatic logic [AW-1:0] next_byte(input logic [AW-1:0] p,
                                              input logic [AW-1:0] l);
    return (p >= l) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [BW-1:0] next_bit(input logic [BW-1:0] i);
    return (i == LAST_BIT) ? '0 : i + 1'b1;
  endfunction

  assign order     = bit_order_e'(lsb_first);
  assign advance   = clk_en && !restart;
  assign byte_done = (bit_idx == LAST_BIT);
  assign ptr_wrap  = byte_done && (byte_ptr >= len_cfg);
  assign rd_addr   = byte_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_ptr <= '0;
      bit_idx  <= '0;
      sdata    <= 1'b0;
    end else if (restart) begin
      byte_ptr <= '0;
      bit_idx  <= '0;
    end else if (clk_en) begin
      sdata   <= pick_bit(rd_data, bit_idx, order);
      bit_idx <= next_bit(bit_idx);
      if (byte_done) byte_ptr <= next_byte(byte_ptr, len_cfg);
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(sdata));

  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !restart) |=> ($stable(byte_ptr) && $stable(bit_idx)));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (byte_ptr == '0 && bit_idx == '0 && $stable(sdata)));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && ptr_wrap) |=> byte_ptr == '0);

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && byte_done && !ptr_wrap) |=> byte_ptr == $past(byte_ptr) + 1'b1);

  p_mid_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !byte_done) |=> $stable(byte_ptr));
endmodule

// File: rtl/ram_pattern_gen.sv
module ram_pattern_gen
  import rpg_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int DEPTH  = DEF_DEPTH,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [AW-1:0]     addr_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     len_cfg,
  input  logic              lsb_first,
  input  logic              restart,
  input  logic              clk_en,
  output logic              sdata
);
  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [AW-1:0]     mem_raddr;
  logic [DATA_W-1:0] mem_rdata;

  rpg_host_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_host (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_load (addr_load),
    .addr_in   (addr_in),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata)
  );

  rpg_pattern_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  rpg_serializer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_cfg   (len_cfg),
    .lsb_first (lsb_first),
    .restart   (restart),
    .clk_en    (clk_en),
    .rd_data   (mem_rdata),
    .rd_addr   (mem_raddr),
    .sdata     (sdata)
  );
endmodule

// File: tb/ram_pattern_gen_tb.sv
module ram_pattern_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 1'b0;
  logic [8:0] addr_in = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [8:0] len_cfg = '0;
  logic       lsb_first = 1'b0;
  logic       restart = 1'b0;
  logic       clk_en = 1'b0;
  logic       sdata;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [7:0] shadow [512];
  int m_ptr = 0;
  int m_bit = 0;
  int m_len = 0;
  int m_lsb = 0;

  typedef struct packed {
    logic [8:0]  len;
    logic        lsb;
    logic [12:0] nbits;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{9'd0,   1'b0, 13'd24},
    '{9'd2,   1'b1, 13'd48},
    '{9'd3,   1'b0, 13'd64},
    '{9'd7,   1'b1, 13'd80},
    '{9'd511, 1'b0, 13'd4112}
  };

  ram_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .wr_en(wr_en), .wr_data(wr_data), .len_cfg(len_cfg), .lsb_first(lsb_first),
    .restart(restart), .clk_en(clk_en), .sdata(sdata)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic set_addr(input int a);
    addr_load = 1'b1;
    addr_in = 9'(a);
    tick();
    addr_load = 1'b0;
  endtask

  // Bench model of the replay, taken from R4 to R7.
  function automatic logic model_bit();
    logic [7:0] b;
    b = shadow[m_ptr];
    return (m_lsb != 0) ? b[m_bit] : b[7 - m_bit];
  endfunction

  task automatic model_step();
    if (m_bit == 7) begin
      m_bit = 0;
      m_ptr = (m_ptr >= m_len) ? 0 : m_ptr + 1;
    end else begin
      m_bit = m_bit + 1;
    end
  endtask

  task automatic do_restart();
    restart = 1'b1;
    tick();
    restart = 1'b0;
    m_ptr = 0;
    m_bit = 0;
  endtask

  task automatic run_bits(input int n, input string tag);
    logic e;
    clk_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      e = model_bit();
      model_step();
      tick();
      check(tag, sdata, e);
    end
    clk_en = 1'b0;
  endtask

  task automatic config_mode(input int len, input int lsb);
    len_cfg = 9'(len);
    lsb_first = lsb[0];
    m_len = len;
    m_lsb = lsb;
  endtask

  initial begin
    logic held;
    logic [39:0] five;
    logic [4:0]  pat;
    string tag;

    // R1: reset state
    tick();
    tick();
    check("R1", sdata, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1", sdata, 1'b0);

    // Fill all 512 bytes from address 0 (R1: write address starts at 0)
    for (int i = 0; i < 512; i++) begin
      shadow[i] = 8'((i * 29 + 7) ^ (i >> 3));
      put_byte(shadow[i]);
    end
    check("R8", sdata, 1'b0);

    // R3: the next write wraps onto byte 0
    put_byte(8'h3C);
    shadow[0] = 8'h3C;

    // R2: load the address, then write two bytes with auto-increment
    set_addr(2);
    put_byte(8'h5A);
    put_byte(8'hC3);
    shadow[2] = 8'h5A;
    shadow[3] = 8'hC3;

    // R3: wrapped byte 0 read back alone
    config_mode(0, 0);
    do_restart();
    run_bits(16, "R3");

    // R2: loaded addresses read back
    config_mode(3, 0);
    do_restart();
    run_bits(32, "R2");

    // Table walk: R4/R5 bit order, R6 length and wrap
    foreach (VECS[k]) begin
      config_mode(int'(VECS[k].len), int'(VECS[k].lsb));
      do_restart();
      if (VECS[k].len == 9'd0 || VECS[k].len == 9'd511) tag = "R6";
      else if (VECS[k].lsb) tag = "R5";
      else tag = "R4";
      run_bits(int'(VECS[k].nbits), tag);
    end

    // R7: lower L in the middle of byte 5
    config_mode(7, 0);
    do_restart();
    run_bits(43, "R7");
    config_mode(2, 0);
    run_bits(5, "R7");
    run_bits(16, "R7");

    // R8: enable low holds output and position
    config_mode(3, 1);
    do_restart();
    run_bits(11, "R8");
    held = sdata;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R8", sdata, held);
    end
    run_bits(21, "R8");

    // R9: restart with enable high holds output, then replay from byte 0
    run_bits(3, "R9");
    held = sdata;
    clk_en = 1'b1;
    restart = 1'b1;
    tick();
    restart = 1'b0;
    clk_en = 1'b0;
    check("R9", sdata, held);
    m_ptr = 0;
    m_bit = 0;
    run_bits(16, "R9");

    // R10: 5-bit pattern stored eight times in 5 bytes
    pat = 5'b10110;
    for (int i = 0; i < 8; i++) five[39 - 5*i -: 5] = pat;
    set_addr(0);
    for (int b = 0; b < 5; b++) put_byte(five[39 - 8*b -: 8]);
    config_mode(4, 0);
    do_restart();
    clk_en = 1'b1;
    for (int i = 0; i < 80; i++) begin
      tick();
      check("R10", sdata, pat[4 - (i % 5)]);
    end
    clk_en = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule